// File: doc/BRIEF.md
# MSI Snooping Cache Controller

This block is the coherence engine of a small direct-mapped writeback cache that sits on a shared snooping bus beside other caches. Each line carries a tag, a data word and one of three coherence states: Modified (dirty, the only valid copy), Shared (clean, other caches may hold it) or Invalid. Processor reads and writes are served locally when the line state allows it. Otherwise the controller asks for the bus, waits for the grant and the acknowledge, and issues a read, a read-for-ownership or a writeback of a dirty victim.

At the same time the controller watches read and read-for-ownership transactions that other caches place on the bus. When one of them hits a local line, the line is downgraded or invalidated in the same cycle. If the line is dirty, its data is driven out as a flush so that memory and the requester see the current value. A snoop always wins over the local processor in the same cycle. The processor access then completes in a later cycle, against the state the snoop left behind.

An address splits into an index (the low `IDX_W` bits) and a tag (the remaining upper bits). Bus commands use a two-bit code: 00 none, 01 read, 10 read-for-ownership, 11 writeback.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address needs the bus. Right after reset `bus_req`, `cpu_busy`, `snp_flush` and `bus_cmd` are 0.
- R2: A read that misses drives `bus_req` with `bus_cmd` = 01 and `bus_addr` = `cpu_addr`. At the cycle with `bus_gnt` and `bus_ack` both high the line takes `bus_rdata` in state Shared. The read then completes with that data.
- R3: A write to an Invalid line, or to a Shared line with a matching tag, drives `bus_cmd` = 10. The line becomes Modified, and the write then completes without further bus traffic.
- R4: A read that hits a Shared or Modified line, and a write that hits a Modified line, raise `cpu_done` combinationally in the cycle of the request and leave `bus_req` low. A read returns the line data on `cpu_rdata`.
- R5: A snooped read (`snp_cmd` = 01) that hits a Modified line raises `snp_flush` in that cycle with the line data on `snp_data`, and leaves the line Shared. A later local write then needs code 10.
- R6: A snooped read that hits a Shared line neither flushes nor changes the line. A snooped read-for-ownership (10) that hits a Shared line invalidates it without a flush.
- R7: A snooped read-for-ownership that hits a Modified line flushes the line data and leaves the line Invalid.
- R8: A miss whose indexed line is Modified under another tag first issues `bus_cmd` = 11, with `bus_addr` = {victim tag, index} and `bus_wdata` = the dirty data. The line then becomes Invalid and the fetch (01 or 10) follows.
- R9: `bus_req` stays high until a cycle with `bus_gnt` and `bus_ack`. `cpu_busy` is high while a request is pending and not done. `bus_cmd` is 00 whenever `bus_req` is low.
- R10: When `snp_valid` is high in the same cycle as a request that would otherwise complete locally, `cpu_done` stays low in that cycle. The request is served afterwards against the state the snoop left.
- R11: A snoop whose tag differs from the stored tag, and a snooped writeback (11), change no line and do not flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | Request completes in this cycle |
| cpu_busy | output | 1 | Request pending and stalled |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_ack | input | 1 | Transfer acknowledge, with fill data |
| bus_cmd | output | 2 | Command: 00 none, 01 read, 10 read-for-ownership, 11 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_rdata | input | DATA_W | Fill data |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | Snooped command, same code as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | Dirty data being supplied this cycle |
| snp_data | output | DATA_W | Flushed data |

## Verification
The assertions assume a serialized bus. `bus_ack` arrives only together with `bus_gnt`, and no snoop arrives in a cycle in which this cache's own transfer is granted. They also assume the processor holds its request, address and data stable until `cpu_done`. The bench keeps to these rules: its bus model grants and acknowledges in a single cycle, it issues snoops only while no local transfer is granted, and it holds the request fields until completion.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;
  typedef enum logic [1:0] {ST_I = 2'b00, ST_S = 2'b01, ST_M = 2'b10} line_st_e;
  typedef enum logic [1:0] {CMD_NONE = 2'b00, CMD_RD = 2'b01,
                            CMD_RDX = 2'b10, CMD_WB = 2'b11} bus_cmd_e;

  // State a snooped command leaves behind on a tag hit
  function automatic line_st_e snoop_next(line_st_e st, bus_cmd_e cmd);
    case (cmd)
      CMD_RD:  return (st == ST_M) ? ST_S : st;
      CMD_RDX: return ST_I;
      default: return st;
    endcase
  endfunction

  // Dirty data must be supplied on a snooped read or read-for-ownership
  function automatic logic snoop_flush(line_st_e st, bus_cmd_e cmd);
    return (st == ST_M) && (cmd == CMD_RD || cmd == CMD_RDX);
  endfunction

  // Access can be served without the bus (tag already matched)
  function automatic logic local_ok(line_st_e st, logic we);
    return (st == ST_M) || (st == ST_S && !we);
  endfunction

  function automatic line_st_e fill_state(bus_cmd_e cmd);
    return (cmd == CMD_RDX) ? ST_M : ST_S;
  endfunction
endpackage

// File: rtl/msi_store.sv
`timescale 1ns/1ps
module msi_store
  import msi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor side port
  input  logic [IDX_W-1:0]  c_idx,
  output line_st_e          c_st,
  output logic [TAG_W-1:0]  c_tag,
  output logic [DATA_W-1:0] c_data,
  input  logic              c_we,
  input  line_st_e          c_wst,
  input  logic [TAG_W-1:0]  c_wtag,
  input  logic [DATA_W-1:0] c_wdata,
  // snoop side port (state only)
  input  logic [IDX_W-1:0]  s_idx,
  output line_st_e          s_st,
  output logic [TAG_W-1:0]  s_tag,
  output logic [DATA_W-1:0] s_data,
  input  logic              s_we,
  input  line_st_e          s_wst
);
  line_st_e          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  assign c_st   = st_q[c_idx];
  assign c_tag  = tag_q[c_idx];
  assign c_data = dat_q[c_idx];
  assign s_st   = st_q[s_idx];
  assign s_tag  = tag_q[s_idx];
  assign s_data = dat_q[s_idx];

  // Snoop update is written last so it wins on the same index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else begin
      if (c_we) st_q[c_idx] <= c_wst;
      if (s_we) st_q[s_idx] <= s_wst;
    end
  end

  always_ff @(posedge clk) begin
    if (c_we) begin
      tag_q[c_idx] <= c_wtag;
      dat_q[c_idx] <= c_wdata;
    end
  end
endmodule

// File: rtl/msi_req.sv
`timescale 1ns/1ps
module msi_req
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_busy,
  input  logic              snp_valid,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              bus_ack,
  output bus_cmd_e          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [IDX_W-1:0]  l_idx,
  input  line_st_e          l_st,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic [DATA_W-1:0] l_data,
  output logic              w_en,
  output line_st_e          w_st,
  output logic [TAG_W-1:0]  w_tag,
  output logic [DATA_W-1:0] w_data
);
  logic [TAG_W-1:0] req_tag;
  logic tag_match, tag_hit, serve_local, dirty_victim, xfer;

  assign l_idx        = cpu_addr[IDX_W-1:0];
  assign req_tag      = cpu_addr[ADDR_W-1:IDX_W];
  assign tag_match    = (l_tag == req_tag);
  assign tag_hit      = (l_st != ST_I) && tag_match;
  assign serve_local  = tag_hit && local_ok(l_st, cpu_we);
  assign dirty_victim = (l_st == ST_M) && !tag_match;

  // Snoop has the line this cycle: local completion waits
  assign cpu_done  = cpu_req && serve_local && !snp_valid;
  assign cpu_busy  = cpu_req && !cpu_done;
  assign cpu_rdata = l_data;

  assign bus_req = cpu_req && !serve_local;
  always_comb begin
    if (!bus_req)          bus_cmd = CMD_NONE;
    else if (dirty_victim) bus_cmd = CMD_WB;
    else if (cpu_we)       bus_cmd = CMD_RDX;
    else                   bus_cmd = CMD_RD;
  end
  assign bus_addr  = dirty_victim ? {l_tag, l_idx} : cpu_addr;
  assign bus_wdata = l_data;
  assign xfer      = bus_req && bus_gnt && bus_ack;

  always_comb begin
    w_en   = xfer || (cpu_done && cpu_we);
    w_st   = ST_M;
    w_tag  = l_tag;
    w_data = cpu_wdata;
    if (xfer) begin
      if (bus_cmd == CMD_WB) begin
        w_st   = ST_I;
        w_data = l_data;
      end else begin
        w_st   = fill_state(bus_cmd);
        w_tag  = req_tag;
        w_data = bus_rdata;
      end
    end
  end

  // R9: an ungranted request is kept up while the processor holds it
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !xfer) |=>
      (!(cpu_req && $stable(cpu_addr) && $stable(cpu_we)) || bus_req));

  // R2 and R3: after a fill the held request completes next cycle
  a_r2_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && bus_cmd != CMD_WB) |=>
      (!(cpu_req && $stable(cpu_addr) && $stable(cpu_we) && !snp_valid) || cpu_done));

  // R8: a writeback empties the victim, so the next command is a fetch
  a_r8_wb_once: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && bus_cmd == CMD_WB) |=>
      (!(cpu_req && $stable(cpu_addr)) || bus_cmd != CMD_WB));

  // R3: a completed write leaves the line dirty, so no bus use follows
  a_r3_write_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_we) |=> (!(cpu_req && $stable(cpu_addr)) || !bus_req));
endmodule

// File: rtl/msi_snoop.sv
`timescale 1ns/1ps
module msi_snoop
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  bus_cmd_e          snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [IDX_W-1:0]  s_idx,
  input  line_st_e          s_st,
  input  logic [TAG_W-1:0]  s_tag,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_we,
  output line_st_e          s_wst,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  logic snp_hit;

  assign s_idx     = snp_addr[IDX_W-1:0];
  assign snp_hit   = snp_valid && (s_st != ST_I) && (s_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign s_we      = snp_hit;
  assign s_wst     = snoop_next(s_st, snp_cmd);
  assign snp_flush = snp_hit && snoop_flush(s_st, snp_cmd);
  assign snp_data  = s_data;

  // R5 and R7: a flush leaves the line clean, so the same snoop cannot flush twice
  a_r5_single_flush: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |=> !(snp_flush && $stable(snp_addr)));
endmodule

// File: rtl/msi_snoop_cache.sv
`timescale 1ns/1ps
module msi_snoop_cache
  import msi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_busy,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              bus_ack,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  c_idx, s_idx;
  line_st_e          c_st, s_st, c_wst, s_wst;
  logic [TAG_W-1:0]  c_tag, s_tag, c_wtag;
  logic [DATA_W-1:0] c_data, s_data, c_wdata;
  logic              c_we, s_we;
  bus_cmd_e          cmd_e;

  assign bus_cmd = cmd_e;

  msi_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .c_idx(c_idx), .c_st(c_st), .c_tag(c_tag), .c_data(c_data),
    .c_we(c_we), .c_wst(c_wst), .c_wtag(c_wtag), .c_wdata(c_wdata),
    .s_idx(s_idx), .s_st(s_st), .s_tag(s_tag), .s_data(s_data),
    .s_we(s_we), .s_wst(s_wst)
  );

  msi_req #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
    .snp_valid(snp_valid),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_cmd(cmd_e),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .l_idx(c_idx), .l_st(c_st), .l_tag(c_tag), .l_data(c_data),
    .w_en(c_we), .w_st(c_wst), .w_tag(c_wtag), .w_data(c_wdata)
  );

  msi_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_addr(snp_addr),
    .s_idx(s_idx), .s_st(s_st), .s_tag(s_tag), .s_data(s_data),
    .s_we(s_we), .s_wst(s_wst), .snp_flush(snp_flush), .snp_data(snp_data)
  );
endmodule

// File: tb/msi_snoop_cache_test.sv
`timescale 1ns/1ps
module msi_snoop_cache_test;
  localparam logic [1:0] NONE = 2'd0, RD = 2'd1, RDX = 2'd2, WB = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, cpu_done, cpu_busy;
  logic [7:0] cpu_addr = 0, bus_addr, snp_addr = 0;
  logic [15:0] cpu_wdata = 0, cpu_rdata, bus_wdata, bus_rdata = 0, snp_data;
  logic bus_req, bus_gnt = 0, bus_ack = 0, snp_valid = 0, snp_flush;
  logic [1:0] bus_cmd, snp_cmd = 0;

  always #2.5 clk = ~clk;

  msi_snoop_cache uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_flush(snp_flush), .snp_data(snp_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] mem  [256];
  logic [15:0] gold [256];
  int acc_n;
  logic [1:0] acc_c0, acc_c1;
  logic acc_ok;
  logic [15:0] acc_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One processor access with a bus model that grants and acknowledges at once
  task automatic access(input logic we, input logic [7:0] a, input logic [15:0] d);
    acc_n = 0; acc_c0 = NONE; acc_c1 = NONE; acc_ok = 0; acc_rd = '0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    for (int k = 0; k < 12; k++) begin
      #1;
      if (cpu_done) begin
        acc_ok = 1; acc_rd = cpu_rdata;
        @(negedge clk);
        break;
      end
      if (bus_req) begin
        if (acc_n == 0) acc_c0 = bus_cmd; else acc_c1 = bus_cmd;
        acc_n++;
        if (bus_cmd == WB) begin
          chk("R8 writeback data", bus_wdata, gold[bus_addr]);
          mem[bus_addr] = bus_wdata;
        end
        bus_rdata = mem[bus_addr];
        bus_gnt = 1; bus_ack = 1;
        @(negedge clk);
        bus_gnt = 0; bus_ack = 0;
      end else begin
        @(negedge clk);
      end
    end
    cpu_req = 0;
    if (we && acc_ok) gold[a] = d;
  endtask

  task automatic expect_access(input string tag, input logic we, input logic [7:0] a,
                               input logic [15:0] d, input int n,
                               input logic [1:0] c0, input logic [1:0] c1);
    logic [15:0] exp_rd;
    exp_rd = gold[a];
    access(we, a, d);
    chk({tag, " done"}, acc_ok, 1);
    chk({tag, " bus count"}, acc_n, n);
    chk({tag, " first cmd"}, acc_c0, c0);
    chk({tag, " second cmd"}, acc_c1, c1);
    if (!we) chk({tag, " read data"}, acc_rd, exp_rd);
  endtask

  task automatic snoop(input string tag, input logic [1:0] c, input logic [7:0] a,
                       input logic expf);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1;
    chk({tag, " flush"}, snp_flush, expf);
    if (expf) begin
      chk({tag, " flush data"}, snp_data, gold[a]);
      mem[a] = snp_data;
    end
    @(negedge clk);
    snp_valid = 0;
  endtask

  typedef struct packed {
    logic       we;
    logic [7:0] addr;
    logic [15:0] wdata;
    logic [1:0] n;
    logic [1:0] c0;
    logic [1:0] c1;
  } vec_t;

  // Index = addr[1:0], tag = addr[7:2]
  localparam vec_t VEC [12] = '{
    '{1'b0, 8'h10, 16'h0000, 2'd1, RD,  NONE},  // R1 R2 cold miss
    '{1'b0, 8'h10, 16'h0000, 2'd0, NONE, NONE}, // R4 read hit S
    '{1'b1, 8'h10, 16'h1111, 2'd1, RDX, NONE},  // R3 write to S
    '{1'b1, 8'h10, 16'h2222, 2'd0, NONE, NONE}, // R4 write hit M
    '{1'b0, 8'h10, 16'h0000, 2'd0, NONE, NONE}, // R4 read hit M
    '{1'b0, 8'h20, 16'h0000, 2'd2, WB,  RD},    // R8 dirty victim
    '{1'b1, 8'h31, 16'h3333, 2'd1, RDX, NONE},  // R3 write to I
    '{1'b0, 8'h31, 16'h0000, 2'd0, NONE, NONE}, // R4
    '{1'b0, 8'h20, 16'h0000, 2'd0, NONE, NONE}, // R4
    '{1'b1, 8'h41, 16'h4444, 2'd2, WB,  RDX},   // R8 then R3
    '{1'b0, 8'h31, 16'h0000, 2'd2, WB,  RD},    // R8 data came back via memory
    '{1'b0, 8'h02, 16'h0000, 2'd1, RD,  NONE}   // R2
  };

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]  = {i[7:0], ~i[7:0]};
      gold[i] = {i[7:0], ~i[7:0]};
    end
    repeat (3) @(negedge clk);
    #1;
    chk("R1 bus_req after reset", bus_req, 0);
    chk("R1 cpu_busy after reset", cpu_busy, 0);
    chk("R1 snp_flush after reset", snp_flush, 0);
    chk("R9 bus_cmd idle", bus_cmd, NONE);
    @(negedge clk) rst_n = 1;

    for (int v = 0; v < 12; v++)
      expect_access("R1 R2 R3 R4 R8 table", VEC[v].we, VEC[v].addr, VEC[v].wdata,
                    int'(VEC[v].n), VEC[v].c0, VEC[v].c1);

    // Line at index 1 holds 0x31 in S
    expect_access("R3 write over clean victim", 1, 8'h05, 16'hAAAA, 1, RDX, NONE);
    snoop("R5 snoop read on M", RD, 8'h05, 1);
    expect_access("R5 line now S read hit", 0, 8'h05, 16'h0, 0, NONE, NONE);
    expect_access("R5 line now S write needs upgrade", 1, 8'h05, 16'hBBBB, 1, RDX, NONE);
    snoop("R7 snoop rdx on M", RDX, 8'h05, 1);
    expect_access("R7 line now I", 0, 8'h05, 16'h0, 1, RD, NONE);
    snoop("R6 snoop read on S", RD, 8'h05, 0);
    expect_access("R6 line stays S", 0, 8'h05, 16'h0, 0, NONE, NONE);
    snoop("R6 snoop rdx on S", RDX, 8'h05, 0);
    expect_access("R6 line invalidated", 0, 8'h05, 16'h0, 1, RD, NONE);
    snoop("R11 snoop other tag", RDX, 8'h09, 0);
    expect_access("R11 line untouched by other tag", 0, 8'h05, 16'h0, 0, NONE, NONE);
    snoop("R11 snooped writeback", WB, 8'h05, 0);
    expect_access("R11 line untouched by writeback", 0, 8'h05, 16'h0, 0, NONE, NONE);

    // R10: snoop read collides with a write hit on M
    expect_access("R10 setup", 1, 8'h05, 16'hCCCC, 1, RDX, NONE);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h05; cpu_wdata = 16'hDDDD;
    snp_valid = 1; snp_cmd = RD; snp_addr = 8'h05;
    #1;
    chk("R10 done held during snoop", cpu_done, 0);
    chk("R10 snoop flushes first", snp_flush, 1);
    chk("R10 flush data", snp_data, 16'hCCCC);
    mem[8'h05] = snp_data;
    @(negedge clk);
    snp_valid = 0;
    #1;
    chk("R10 done after downgrade", cpu_done, 0);
    chk("R10 upgrade needed", bus_cmd, RDX);
    bus_rdata = mem[8'h05]; bus_gnt = 1; bus_ack = 1;
    @(negedge clk);
    bus_gnt = 0; bus_ack = 0;
    #1;
    chk("R10 write completes", cpu_done, 1);
    @(negedge clk);
    cpu_req = 0; gold[8'h05] = 16'hDDDD;
    expect_access("R10 written data kept", 0, 8'h05, 16'h0, 0, NONE, NONE);

    // R9: grant held off for three cycles
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h0A;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R9 req held", bus_req, 1);
      chk("R9 busy", cpu_busy, 1);
      chk("R2 cmd read", bus_cmd, RD);
      chk("R2 bus addr", bus_addr, 8'h0A);
      @(negedge clk);
    end
    bus_rdata = mem[8'h0A]; bus_gnt = 1; bus_ack = 1;
    @(negedge clk);
    bus_gnt = 0; bus_ack = 0;
    #1;
    chk("R9 done after grant", cpu_done, 1);
    chk("R2 fill data", cpu_rdata, gold[8'h0A]);
    chk("R9 no request once served", bus_req, 0);
    @(negedge clk);
    cpu_req = 0;
    #1;
    chk("R9 idle cmd", bus_cmd, NONE);
    chk("R9 idle busy", cpu_busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule